// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is a cycle-accurate, synchronous model of the command front end of a parallel NOR flash. It watches host write cycles made of a word address, a 16-bit data word and an active-low write strobe qualified by chip enable. It follows the multi-cycle unlock sequences that guard programming and erasing. When a program, sector-erase, block-erase or chip-erase sequence completes, the block raises a busy flag for a parameterised number of clock cycles. When that time runs out it applies the operation to a small on-chip word array.

Reads use chip enable and output enable and return the stored word one cycle later. While an operation runs, a read returns a status word instead. Its bit 7 is the polling bit and its bit 6 is a toggle bit. Any command that the host writes while the block is busy is dropped.

Storage is a window of the 1M-word address space. The modelled words are those whose address is zero everywhere except bits [1:0], [12:11] and [16:15], which gives 64 words. Reads anywhere else return all ones, and programs anywhere else change nothing. Sequence matching still sees the full address.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, busy is 0, dout is 0 and every modelled word reads FFFFh.
- R2: The writes AAh@5555h, 55h@2AAAh, A0h@5555h and then D@A start a program. Command codes are compared on din[7:0] and command addresses on addr[14:0]. When busy falls, the word at A reads old AND D.
- R3: A program only clears bits. A second program of the same word gives the AND of both data values with the word's previous contents.
- R4: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh and then 30h@SA erase every modelled word whose addr[19:11] equals SA[19:11] to FFFFh. Every other word keeps its value.
- R5: The same five cycles followed by 50h@BA erase every modelled word whose addr[19:15] equals BA[19:15]. Every other word keeps its value.
- R6: The same five cycles followed by 10h@5555h set every modelled word to FFFFh. A sixth cycle of 10h at any other address starts nothing.
- R7: If any unlock or setup cycle carries the wrong data or the wrong address, the decoder returns to idle. The rest of that sequence starts no operation and changes no word.
- R8: While busy is 1, every write is ignored. A complete command written during that time neither lengthens the busy period nor changes any word.
- R9: The address of a write cycle is captured on the clock edge that first sees ce_n and we_n both low. The data is taken on the edge that first sees the strobe ended.
- R10: busy is 1 starting with the clock edge that sees the final strobe end. It stays 1 for exactly PROG_CYCLES cycles after a program and ERASE_CYCLES cycles after any erase.
- R11: A read while busy returns a status word. Bit 7 is the complement of the programmed data's bit 7, or 0 during an erase. Bit 6 flips between consecutive reads, and all other bits are 0.
- R12: dout is registered and shows the read one cycle after ce_n and oe_n are low. It is 0 when no read is active. A word outside the modelled window reads FFFFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Word address |
| din | input | DW | Write data |
| dout | output | DW | Registered read data or status word |
| busy | output | 1 | Internal program or erase in progress |

## Verification
If the sequence state is wrong, the error shows up at the last cycle of a command. Busy either fails to rise on the edge after the final strobe, or it rises after a broken sequence. Both are visible one cycle later. A timer that counts wrong shows as a busy period whose length differs from the parameter, and this is measured to the exact cycle. Wrong address-slice matching or a wrong AND at completion shows only on the first read after busy falls. For that reason every operation is followed by reads of words both inside and outside the targeted sector or block.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int CMP_AW = 15;
  localparam int CODE_W = 8;

  localparam logic [CMP_AW-1:0] ADR_KEY_A = 15'h5555;
  localparam logic [CMP_AW-1:0] ADR_KEY_B = 15'h2AAA;

  localparam logic [CODE_W-1:0] CODE_KEY_A = 8'hAA;
  localparam logic [CODE_W-1:0] CODE_KEY_B = 8'h55;
  localparam logic [CODE_W-1:0] CODE_PROG  = 8'hA0;
  localparam logic [CODE_W-1:0] CODE_ERSET = 8'h80;
  localparam logic [CODE_W-1:0] CODE_SECT  = 8'h30;
  localparam logic [CODE_W-1:0] CODE_BLK   = 8'h50;
  localparam logic [CODE_W-1:0] CODE_CHIP  = 8'h10;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_KEY1, SQ_KEY2, SQ_PGM, SQ_ER1, SQ_ER2, SQ_ER3
  } seq_t;

  typedef enum logic [1:0] {OP_PROG, OP_SECT, OP_BLK, OP_CHIP} op_t;
endpackage

// File: rtl/flash_bus_edge.sv
module flash_bus_edge #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  output logic          wr_evt_o,
  output logic [AW-1:0] wr_addr_o
);
  logic strb, strb_q, strb_rise;
  logic [AW-1:0] addr_q;

  assign strb      = ~ce_n & ~we_n;
  assign strb_rise = strb & ~strb_q;
  assign wr_evt_o  = ~strb & strb_q;
  assign wr_addr_o = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q <= 1'b0;
    end else begin
      strb_q <= strb;
    end
  end

  // address taken when the strobe begins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (strb_rise) begin
      addr_q <= addr;
    end
  end
endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_evt_i,
  input  logic [CMP_AW-1:0] cmd_addr_i,
  input  logic [CODE_W-1:0] cmd_code_i,
  input  logic              busy_i,
  output logic              start_o,
  output op_t               op_o
);
  seq_t state, state_nxt;
  logic at_a, at_b;

  assign at_a = (cmd_addr_i == ADR_KEY_A);
  assign at_b = (cmd_addr_i == ADR_KEY_B);

  always_comb begin
    state_nxt = state;
    start_o   = 1'b0;
    op_o      = OP_PROG;
    if (wr_evt_i && !busy_i) begin
      state_nxt = SQ_IDLE;
      case (state)
        SQ_IDLE: if (at_a && cmd_code_i == CODE_KEY_A) state_nxt = SQ_KEY1;
        SQ_KEY1: if (at_b && cmd_code_i == CODE_KEY_B) state_nxt = SQ_KEY2;
        SQ_KEY2: begin
          if (at_a && cmd_code_i == CODE_PROG)       state_nxt = SQ_PGM;
          else if (at_a && cmd_code_i == CODE_ERSET) state_nxt = SQ_ER1;
        end
        SQ_PGM: begin
          start_o = 1'b1;
          op_o    = OP_PROG;
        end
        SQ_ER1: if (at_a && cmd_code_i == CODE_KEY_A) state_nxt = SQ_ER2;
        SQ_ER2: if (at_b && cmd_code_i == CODE_KEY_B) state_nxt = SQ_ER3;
        SQ_ER3: begin
          if (cmd_code_i == CODE_SECT) begin
            start_o = 1'b1;
            op_o    = OP_SECT;
          end else if (cmd_code_i == CODE_BLK) begin
            start_o = 1'b1;
            op_o    = OP_BLK;
          end else if (at_a && cmd_code_i == CODE_CHIP) begin
            start_o = 1'b1;
            op_o    = OP_CHIP;
          end
        end
        default: state_nxt = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SQ_IDLE;
    else        state <= state_nxt;
  end

  // R8: the timer's busy flag must block any new start
  assert_no_start_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> !start_o);
endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
  parameter int PROG_CYCLES  = 20,
  parameter int ERASE_CYCLES = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic erase_i,
  output logic busy_o,
  output logic done_o
);
  localparam int MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt, cnt_nxt;
  logic          cnt_en;

  assign busy_o = (cnt != '0);
  assign done_o = (cnt == CW'(1));
  assign cnt_en = start_i | busy_o;

  always_comb begin
    if (start_i) cnt_nxt = erase_i ? CW'(ERASE_CYCLES) : CW'(PROG_CYCLES);
    else         cnt_nxt = cnt - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_nxt;
  end

  assert_busy_after_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o);
  assert_busy_ends_on_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(done_o));
endmodule

// File: rtl/flash_word_array.sv
module flash_word_array
  import flash_cmd_pkg::*;
#(
  parameter int AW      = 20,
  parameter int DW      = 16,
  parameter int FIELD_W = 2,
  parameter int SEC_LSB = 11,
  parameter int BLK_LSB = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  op_t           op_i,
  input  logic [AW-1:0] op_addr_i,
  input  logic [DW-1:0] op_data_i,
  input  logic          done_i,
  input  logic          busy_i,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] dout
);
  localparam int IDX_W = 3 * FIELD_W;
  localparam int DEPTH = 1 << IDX_W;

  function automatic logic [AW-1:0] win_mask();
    logic [AW-1:0] m;
    m = '0;
    for (int k = 0; k < FIELD_W; k++) begin
      m[k]           = 1'b1;
      m[SEC_LSB + k] = 1'b1;
      m[BLK_LSB + k] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [AW-1:0] WMASK = win_mask();

  function automatic logic [IDX_W-1:0] idx_of(logic [AW-1:0] a);
    return {a[BLK_LSB +: FIELD_W], a[SEC_LSB +: FIELD_W], a[0 +: FIELD_W]};
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] mem_nxt [DEPTH];
  logic [DEPTH-1:0] clr_hit;

  op_t           p_op;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_data;
  logic          p_in_win;
  logic [IDX_W-1:0] p_idx;

  logic          rd, rd_q, tog, tog_en;
  logic [DW-1:0] status, dout_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_op   <= OP_PROG;
      p_addr <= '0;
      p_data <= '0;
    end else if (start_i) begin
      p_op   <= op_i;
      p_addr <= op_addr_i;
      p_data <= op_data_i;
    end
  end

  assign p_in_win = ((p_addr & ~WMASK) == '0);
  assign p_idx    = idx_of(p_addr);

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    localparam int HI  = (g >> (2 * FIELD_W)) & ((1 << FIELD_W) - 1);
    localparam int MID = (g >> FIELD_W) & ((1 << FIELD_W) - 1);
    localparam int LO  = g & ((1 << FIELD_W) - 1);
    localparam logic [AW-1:0] EA = (AW'(HI) << BLK_LSB) | (AW'(MID) << SEC_LSB) | AW'(LO);
    assign clr_hit[g] = (p_op == OP_CHIP)
      | ((p_op == OP_SECT) && (EA[AW-1:SEC_LSB] == p_addr[AW-1:SEC_LSB]))
      | ((p_op == OP_BLK)  && (EA[AW-1:BLK_LSB] == p_addr[AW-1:BLK_LSB]));
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      if (clr_hit[i])
        mem_nxt[i] = '1;
      else if (p_op == OP_PROG && p_in_win && p_idx == IDX_W'(i))
        mem_nxt[i] = mem[i] & p_data;
      else
        mem_nxt[i] = mem[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (done_i) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= mem_nxt[i];
    end
  end

  // read path with status word during an operation
  assign rd     = ~ce_n & ~oe_n;
  assign tog_en = rd_q & ~rd & busy_i;

  always_comb begin
    status    = '0;
    status[7] = (p_op == OP_PROG) ? ~p_data[7] : 1'b0;
    status[6] = tog;
    if (!rd)                             dout_nxt = '0;
    else if (busy_i)                     dout_nxt = status;
    else if ((addr & ~WMASK) == '0)      dout_nxt = mem[idx_of(addr)];
    else                                 dout_nxt = '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      dout <= '0;
    end else begin
      rd_q <= rd;
      dout <= dout_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tog <= 1'b0;
    else if (tog_en) tog <= ~tog;
  end

  assert_chip_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && p_op == OP_CHIP) |=> (mem[0] == {DW{1'b1}} && mem[DEPTH-1] == {DW{1'b1}}));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int AW           = 20,
  parameter int DW           = 16,
  parameter int FIELD_W      = 2,
  parameter int SEC_LSB      = 11,
  parameter int BLK_LSB      = 15,
  parameter int PROG_CYCLES  = 20,
  parameter int ERASE_CYCLES = 60
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          busy
);
  logic rst_q1, rst_q2;
  logic wr_evt, start, done;
  logic [AW-1:0] wr_addr;
  op_t op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end

  flash_bus_edge #(.AW(AW)) u_edge (
    .clk(clk), .rst_n(rst_q2), .ce_n(ce_n), .we_n(we_n), .addr(addr),
    .wr_evt_o(wr_evt), .wr_addr_o(wr_addr)
  );

  flash_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_q2), .wr_evt_i(wr_evt),
    .cmd_addr_i(wr_addr[CMP_AW-1:0]), .cmd_code_i(din[CODE_W-1:0]),
    .busy_i(busy), .start_o(start), .op_o(op)
  );

  flash_busy_timer #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_q2), .start_i(start), .erase_i(op != OP_PROG),
    .busy_o(busy), .done_o(done)
  );

  flash_word_array #(
    .AW(AW), .DW(DW), .FIELD_W(FIELD_W), .SEC_LSB(SEC_LSB), .BLK_LSB(BLK_LSB)
  ) u_array (
    .clk(clk), .rst_n(rst_q2), .start_i(start), .op_i(op), .op_addr_i(wr_addr),
    .op_data_i(din), .done_i(done), .busy_i(busy), .ce_n(ce_n), .oe_n(oe_n),
    .addr(addr), .dout(dout)
  );
endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb_top;
  localparam int PROG_N  = 20;
  localparam int ERASE_N = 60;

  logic clk = 1'b0;
  logic rst_n;
  logic ce_n, we_n, oe_n;
  logic [19:0] addr;
  logic [15:0] din;
  logic [15:0] dout;
  logic busy;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] model [64];

  always #5 clk = ~clk;

  flash_cmd_decoder #(.PROG_CYCLES(PROG_N), .ERASE_CYCLES(ERASE_N)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .busy(busy)
  );

  function automatic logic [19:0] eaddr(int i);
    return (20'((i >> 4) & 3) << 15) | (20'((i >> 2) & 3) << 11) | 20'(i & 3);
  endfunction

  function automatic bit inwin(logic [19:0] a);
    return (a & ~20'h19803) == 20'h0;
  endfunction

  function automatic int widx(logic [19:0] a);
    return int'({a[16:15], a[12:11], a[1:0]});
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic m_prog(logic [19:0] a, logic [15:0] d);
    if (inwin(a)) model[widx(a)] = model[widx(a)] & d;
  endtask

  task automatic m_erase(logic [19:0] a, int lsb);
    for (int i = 0; i < 64; i++) begin
      logic [19:0] ea;
      ea = eaddr(i);
      if ((ea >> lsb) == (a >> lsb)) model[i] = 16'hFFFF;
    end
  endtask

  task automatic bus_write(logic [19:0] a, logic [15:0] d);
    addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_program(logic [19:0] a, logic [15:0] d);
    bus_write(20'h05555, 16'h00AA);
    bus_write(20'h02AAA, 16'h0055);
    bus_write(20'h05555, 16'h00A0);
    bus_write(a, d);
  endtask

  task automatic do_erase(logic [19:0] a, logic [7:0] code);
    bus_write(20'h05555, 16'h00AA);
    bus_write(20'h02AAA, 16'h0055);
    bus_write(20'h05555, 16'h0080);
    bus_write(20'h05555, 16'h00AA);
    bus_write(20'h02AAA, 16'h0055);
    bus_write(a, {8'h00, code});
  endtask

  task automatic read_word(logic [19:0] a, output logic [15:0] v);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    v = dout;
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy === 1'b1 && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic check_all(string req);
    logic [15:0] v;
    for (int i = 0; i < 64; i++) begin
      read_word(eaddr(i), v);
      check(req, v, model[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] v, v2;
    logic [19:0] a;
    logic [15:0] d;
    int n;
    int seed;
    seed = $urandom(32'd24681);
    for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
    rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; addr = '0; din = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 busy", {15'h0, busy}, 16'h0);
    check("R1 dout", dout, 16'h0);
    check_all("R1 array");

    // R12 latency, idle dout, out-of-window
    read_word(20'h00004, v);
    check("R12 outside window", v, 16'hFFFF);
    check("R12 idle dout", dout, 16'h0);

    // R2 / R10 program timing
    do_program(20'h00001, 16'h1234);
    m_prog(20'h00001, 16'h1234);
    busy_len(n);
    check("R10 program busy length", 16'(n), 16'(PROG_N));
    read_word(20'h00001, v);
    check("R2 program result", v, 16'h1234);

    // R3 AND behaviour
    do_program(20'h00001, 16'hFF00);
    m_prog(20'h00001, 16'hFF00);
    busy_len(n);
    read_word(20'h00001, v);
    check("R3 program clears only", v, 16'h1200);

    // R11 status word during program and erase
    do_program(20'h00002, 16'h00F0);
    m_prog(20'h00002, 16'h00F0);
    read_word(20'h00002, v);
    read_word(20'h00002, v2);
    check("R11 status bits", v & 16'hFFBF, 16'h0000);
    check("R11 toggle", {15'h0, v[6] ^ v2[6]}, 16'h1);
    busy_len(n);
    do_program(20'h00003, 16'h0010);
    m_prog(20'h00003, 16'h0010);
    read_word(20'h00003, v);
    check("R11 poll bit complement", v & 16'hFFBF, 16'h0080);
    busy_len(n);

    // R8 commands ignored while busy
    do_program(20'h08001, 16'h5A5A);
    m_prog(20'h08001, 16'h5A5A);
    do_program(20'h10002, 16'h0000);
    busy_len(n);
    check("R8 busy not extended", 16'(n + 8), 16'(PROG_N));
    read_word(20'h10002, v);
    check("R8 ignored program", v, 16'hFFFF);
    read_word(20'h08001, v);
    check("R8 first program kept", v, 16'h5A5A);

    // R7 broken unlock and broken erase setup
    bus_write(20'h05555, 16'h00AA);
    bus_write(20'h02AAB, 16'h0055);
    bus_write(20'h05555, 16'h00A0);
    bus_write(20'h00800, 16'h0000);
    check("R7 no busy after bad address", {15'h0, busy}, 16'h0);
    read_word(20'h00800, v);
    check("R7 word untouched", v, 16'hFFFF);
    bus_write(20'h05555, 16'h00AA);
    bus_write(20'h02AAA, 16'h0055);
    bus_write(20'h05555, 16'h0080);
    bus_write(20'h05555, 16'h00AA);
    bus_write(20'h02AAA, 16'h0054);
    bus_write(20'h00001, 16'h0030);
    check("R7 no busy after bad code", {15'h0, busy}, 16'h0);
    read_word(20'h00001, v);
    check("R7 erase blocked", v, 16'h1200);

    // fill several words for erase tests
    for (int i = 0; i < 64; i += 5) begin
      do_program(eaddr(i), 16'h0F0F ^ 16'(i));
      m_prog(eaddr(i), 16'h0F0F ^ 16'(i));
      busy_len(n);
    end

    // R4 sector erase, low address bits irrelevant
    do_erase(20'h00803, 8'h30);
    m_erase(20'h00803, 11);
    busy_len(n);
    check("R10 erase busy length", 16'(n), 16'(ERASE_N));
    check_all("R4 sector erase");

    // R5 block erase
    do_erase(20'h08802, 8'h50);
    m_erase(20'h08802, 15);
    busy_len(n);
    check_all("R5 block erase");

    // R9 address at strobe start, data at strobe end
    bus_write(20'h05555, 16'h00AA);
    bus_write(20'h02AAA, 16'h0055);
    bus_write(20'h05555, 16'h00A0);
    addr = 20'h10001; din = 16'hFFFF; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    addr = 20'h10002; din = 16'h3C3C;
    @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
    m_prog(20'h10001, 16'h3C3C);
    busy_len(n);
    read_word(20'h10001, v);
    check("R9 capture", v, model[widx(20'h10001)]);
    read_word(20'h10002, v);
    check("R9 other address", v, model[widx(20'h10002)]);

    // R12 program outside window changes nothing
    do_program(20'h00004, 16'h0000);
    busy_len(n);
    read_word(20'h00000, v);
    check("R12 no alias", v, model[0]);

    // constrained random mix
    for (int it = 0; it < 60; it++) begin
      int r;
      r = $urandom % 10;
      a = eaddr($urandom % 64);
      d = 16'($urandom);
      if (r < 6) begin
        if (r == 0) a = 20'($urandom);
        do_program(a, d);
        m_prog(a, d);
      end else if (r < 8) begin
        a[1:0] = 2'($urandom);
        do_erase(a, 8'h30);
        m_erase(a, 11);
      end else if (r == 8) begin
        do_erase(a, 8'h50);
        m_erase(a, 15);
      end else begin
        bus_write(20'h05555, 16'h00AA);
        bus_write(20'h02AAA, 16'h0056);
        bus_write(20'h05555, 16'h00A0);
        bus_write(a, 16'h0000);
        check("R7 random broken", {15'h0, busy}, 16'h0);
      end
      busy_len(n);
      for (int k = 0; k < 3; k++) begin
        int j;
        j = $urandom % 64;
        read_word(eaddr(j), v);
        check("R2 R4 R5 random read", v, model[j]);
      end
    end

    // R6 chip erase: wrong address first, then correct
    do_erase(20'h05554, 8'h10);
    check("R6 wrong address no busy", {15'h0, busy}, 16'h0);
    do_erase(20'h05555, 8'h10);
    for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
    read_word(20'h00000, v);
    check("R11 erase status", v & 16'hFFBF, 16'h0000);
    busy_len(n);
    check_all("R6 chip erase");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule